// File: doc/BRIEF.md
# Guarded Byte Memory Write Controller

This block sits on a simple CPU register bus and controls a small byte-wide nonvolatile data store. Software reaches it through four byte registers: a pointer, a data holder, a control/status byte and a write-only key port. A read is a single control write. The addressed byte is in the data holder on the cycle that follows.

A write is harder to start, so that runaway code cannot change the store by accident. Three conditions must all hold:
- A fixed two-byte key arrives on the key port, and the write request follows it on consecutive clock cycles.
- A software-owned enable bit is already set.
- The power-up lockout interval after reset has ended.

An accepted write latches the target pointer and byte. It runs for a parameterised number of clock cycles and then commits. A sticky completion flag is then raised, and it is also driven out as an interrupt line.

The write time and the lockout length are counted in clock cycles. A fast test can therefore shrink them. The defaults model about 4 ms and 72 ms at 50 MHz.

Top module: `nvm_ctrl`

## Requirements
- R1: The register offsets are 0 pointer, 1 data holder, 2 control, 3 key port (reads 0). Control bits are bit0 read strobe (reads 0), bit1 write request/busy, bit2 write enable, bit3 done flag. After reset every register reads 0 and `irq_flag` is 0.
- R2: When no write is running, a control write with bit0=1 loads the data holder with the stored byte at the pointer. The value is readable in the cycle right after that access.
- R3: The data holder keeps its value through other accesses until another read or a software write to offset 1.
- R4: A write starts only if three bus writes fall on three consecutive clock cycles: 55h to offset 3, then AAh to offset 3, then a control write with bit1=1. A wrong value, any other access, or an idle cycle in between cancels the sequence.
- R5: A start also needs control bit2 to be 1 before the access that sets bit1. Bit2 is 0 after reset and only software writes change it.
- R6: No write starts during the first LOCKOUT_CYCLES clock cycles after reset.
- R7: Control bit1 reads 1 for exactly WRITE_CYCLES cycles, beginning in the cycle after the starting access. The byte is committed when it falls. The pointer and data value used are the ones held at the start.
- R8: Clearing bit2 while a write runs does not abort the write.
- R9: The commit sets bit3 and `irq_flag`. Both stay set until software writes the control register with bit3=0. Writing 1 to bit3 does not set it.
- R10: A read strobe given while a write is running is ignored, and the data holder is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_flag | output | 1 | Completion interrupt flag |

## Verification
Each result has a fixed due cycle after its triggering access:
- A read result is due in the cycle right after the strobe access.
- Busy is due in the cycle right after the starting access. It stays high for WRITE_CYCLES cycles, and the completion flag appears in the same cycle busy falls.
- Lockout and key failures show as busy still reading 0 in the cycle after the request.

The bench drives on falling edges and looks at the register outputs combinationally, without spending a bus cycle. It counts falling edges from the starting access. It then samples busy and the flag both one cycle before and exactly at the commit, so an off-by-one in the write length is caught.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    RS_PTR  = 2'd0,
    RS_DATA = 2'd1,
    RS_CTRL = 2'd2,
    RS_KEY  = 2'd3
  } reg_sel_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WEN  = 2;
  localparam int CB_DONE = 3;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  function automatic logic [7:0] ctrl_view(input logic done, input logic wen,
                                           input logic busy);
    logic [7:0] v;
    v = 8'h00;
    v[CB_DONE] = done;
    v[CB_WEN]  = wen;
    v[CB_WR]   = busy;
    return v;
  endfunction

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       key_wr,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  output logic       seq_ok
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = KS_IDLE;
    if (acc) begin
      if (key_wr && wdata == KEY_FIRST)
        st_d = KS_HALF;
      else if (st_q == KS_HALF && key_wr && wdata == KEY_SECOND)
        st_d = KS_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign seq_ok = (st_q == KS_ARMED) && acc && ctrl_wr && wdata[CB_WR];
endmodule

// File: rtl/nvm_powerup_gate.sv
module nvm_powerup_gate
  import nvm_pkg::*;
#(
  parameter int LOCKOUT_CYCLES = 3600000
) (
  input  logic clk,
  input  logic rst_n,
  output logic lockout
);
  localparam int LW = cnt_width(LOCKOUT_CYCLES);
  localparam logic [LW-1:0] LIMIT = LW'(LOCKOUT_CYCLES);

  logic [LW-1:0] cnt_q;

  assign lockout = (cnt_q != LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (lockout) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nvm_store.sv
module nvm_store
  import nvm_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              busy,
  output logic              commit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = cnt_width(WRITE_CYCLES);

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [7:0]        tgt_data_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q;

  assign busy    = busy_q;
  assign commit  = busy_q && (cnt_q == '0);
  assign rd_byte = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
    end else if (start && !busy_q) begin
      busy_q     <= 1'b1;
      cnt_q      <= CW'(WRITE_CYCLES - 1);
      tgt_addr_q <= start_addr;
      tgt_data_q <= start_data;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[i] <= 8'h00;
      else if (commit && tgt_addr_q == ADDR_W'(i))
        mem_q[i] <= tgt_data_q;
    end
  end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int WRITE_CYCLES   = 200000,
  parameter int LOCKOUT_CYCLES = 3600000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_valid,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_flag
);
  localparam int PAD = 8 - ADDR_W;

  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        data_q;
  logic              wen_q;
  logic              done_q;

  logic wr_acc, ptr_wr, data_wr, ctrl_wr, key_wr;
  logic seq_ok, lockout, start, busy, commit;
  logic rd_req, rd_take, flag_clr;
  logic [7:0] rd_byte;

  assign wr_acc  = bus_valid && bus_we;
  assign ptr_wr  = wr_acc && reg_sel_e'(bus_addr) == RS_PTR;
  assign data_wr = wr_acc && reg_sel_e'(bus_addr) == RS_DATA;
  assign ctrl_wr = wr_acc && reg_sel_e'(bus_addr) == RS_CTRL;
  assign key_wr  = wr_acc && reg_sel_e'(bus_addr) == RS_KEY;

  assign rd_req   = ctrl_wr && bus_wdata[CB_RD];
  assign rd_take  = rd_req && !busy;
  assign flag_clr = ctrl_wr && !bus_wdata[CB_DONE];
  assign start    = seq_ok && wen_q && !lockout && !busy;

  nvm_key_seq u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (bus_valid),
    .key_wr  (key_wr),
    .ctrl_wr (ctrl_wr),
    .wdata   (bus_wdata),
    .seq_ok  (seq_ok)
  );

  nvm_powerup_gate #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .lockout (lockout)
  );

  nvm_store #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (ptr_q),
    .start_data (data_q),
    .rd_addr    (ptr_q),
    .rd_byte    (rd_byte),
    .busy       (busy),
    .commit     (commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      data_q <= '0;
      wen_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ptr_wr)       ptr_q <= bus_wdata[ADDR_W-1:0];
      if (rd_take)      data_q <= rd_byte;
      else if (data_wr) data_q <= bus_wdata;
      if (ctrl_wr)      wen_q <= bus_wdata[CB_WEN];
      if (commit)       done_q <= 1'b1;
      else if (flag_clr) done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      RS_PTR:  bus_rdata = {{PAD{1'b0}}, ptr_q};
      RS_DATA: bus_rdata = data_q;
      RS_CTRL: bus_rdata = ctrl_view(done_q, wen_q, busy);
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_flag = done_q;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int WRITE_CYCLES = 200000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       seq_ok,
  input logic       wen_q,
  input logic       lockout,
  input logic       busy,
  input logic       commit,
  input logic       irq_flag,
  input logic       flag_clr,
  input logic       ctrl_wr,
  input logic       data_wr,
  input logic       rd_req,
  input logic       rd_take,
  input logic [7:0] rd_byte,
  input logic [7:0] data_q
);
  int bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  p_key_before_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(seq_ok));
  p_enable_before_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));
  p_enable_sw_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_q) |-> $past(ctrl_wr));
  p_no_start_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(lockout));
  p_write_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> bcnt == WRITE_CYCLES - 1);
  p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);
  p_flag_on_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq_flag);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
  p_read_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> data_q == $past(rd_byte));
  p_read_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy && !data_wr) |=> $stable(data_q));
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .seq_ok   (seq_ok),
  .wen_q    (wen_q),
  .lockout  (lockout),
  .busy     (busy),
  .commit   (commit),
  .irq_flag (irq_flag),
  .flag_clr (flag_clr),
  .ctrl_wr  (ctrl_wr),
  .data_wr  (data_wr),
  .rd_req   (rd_req),
  .rd_take  (rd_take),
  .rd_byte  (rd_byte),
  .data_q   (data_q)
);

// File: tb/sim_nvm_ctrl.sv
module sim_nvm_ctrl;
  localparam int AW = 4;
  localparam int WC = 5;
  localparam int LC = 40;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq_flag;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [N];
  logic wen_sh = 1'b0;

  always #10 clk = ~clk;

  nvm_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .LOCKOUT_CYCLES(LC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_flag(irq_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    bus_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_valid = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  function automatic logic [7:0] ctl(input logic rd, input logic wr, input logic en);
    return {4'b0000, 1'b1, en, wr, rd};
  endfunction

  task automatic read_byte(input int a, output logic [7:0] v);
    bwr(2'd0, 8'(a));
    bwr(2'd2, ctl(1'b1, 1'b0, wen_sh));
    peek(2'd1, v);
  endtask

  task automatic key_go();
    bwr(2'd3, 8'h55);
    bwr(2'd3, 8'hAA);
    bwr(2'd2, ctl(1'b0, 1'b1, wen_sh));
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 53 + 17) & 8'hFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      peek(2'(r), v);
      chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq_flag}, 8'h00);

    // R6 attempt inside lockout with everything else correct
    bwr(2'd0, 8'd3);
    bwr(2'd1, 8'h77);
    wen_sh = 1'b1;
    bwr(2'd2, ctl(1'b0, 1'b0, 1'b1));
    key_go();
    peek(2'd2, v);
    chk("R6 busy during lockout", v & 8'h02, 8'h00);
    idle(LC + 2);
    read_byte(3, v);
    chk("R6 array unchanged", v, 8'h00);

    // R5 enable missing
    wen_sh = 1'b0;
    bwr(2'd2, ctl(1'b0, 1'b0, 1'b0));
    bwr(2'd1, 8'h5A);
    key_go();
    peek(2'd2, v);
    chk("R5 no start without enable", v & 8'h02, 8'h00);
    idle(WC + 1);
    read_byte(3, v);
    chk("R5 array unchanged", v, 8'h00);
    // R5 enable set in same access as wr bit is not enough
    bwr(2'd1, 8'h5A);
    bwr(2'd3, 8'h55); bwr(2'd3, 8'hAA);
    bwr(2'd2, ctl(1'b0, 1'b1, 1'b1));
    peek(2'd2, v);
    chk("R5 enable must precede", v & 8'h02, 8'h00);
    wen_sh = 1'b1;
    idle(WC + 1);
    read_byte(3, v);
    chk("R5 array unchanged 2", v, 8'h00);

    // R4 broken sequences
    for (int c = 0; c < 5; c++) begin
      bwr(2'd0, 8'd3); bwr(2'd1, 8'hC3);
      case (c)
        0: begin bwr(2'd3, 8'h55); idle(1); bwr(2'd3, 8'hAA); bwr(2'd2, ctl(0, 1, 1)); end
        1: begin bwr(2'd3, 8'h55); bwr(2'd3, 8'hAA); idle(1); bwr(2'd2, ctl(0, 1, 1)); end
        2: begin bwr(2'd3, 8'hAA); bwr(2'd3, 8'h55); bwr(2'd2, ctl(0, 1, 1)); end
        3: begin bwr(2'd3, 8'h55); bwr(2'd0, 8'd3); bwr(2'd3, 8'hAA); bwr(2'd2, ctl(0, 1, 1)); end
        default: begin bwr(2'd3, 8'h55); bwr(2'd3, 8'hAB); bwr(2'd2, ctl(0, 1, 1)); end
      endcase
      peek(2'd2, v);
      chk("R4 broken sequence no busy", v & 8'h02, 8'h00);
      idle(WC + 1);
      read_byte(3, v);
      chk("R4 array unchanged", v, 8'h00);
    end
    chk("R4 no flag", {7'd0, irq_flag}, 8'h00);

    // R7 R9 exact timing of a good write
    bwr(2'd0, 8'd9); bwr(2'd1, 8'hE1);
    key_go();
    peek(2'd2, v);
    chk("R7 busy right after start", v & 8'h02, 8'h02);
    bwr(2'd0, 8'd2); // R7 pointer change after start must not redirect
    bwr(2'd1, 8'h11);
    repeat (WC - 3) @(negedge clk);
    peek(2'd2, v);
    chk("R7 still busy last cycle", v & 8'h02, 8'h02);
    chk("R9 flag not yet", {7'd0, irq_flag}, 8'h00);
    @(negedge clk);
    peek(2'd2, v);
    chk("R7 busy dropped", v & 8'h02, 8'h00);
    chk("R9 flag set", {7'd0, irq_flag}, 8'h01);
    chk("R9 done bit", v & 8'h08, 8'h08);
    model[9] = 8'hE1;
    read_byte(9, v);
    chk("R7 committed byte", v, 8'hE1);
    read_byte(2, v);
    chk("R7 other byte untouched", v, 8'h00);
    chk("R9 flag sticky", {7'd0, irq_flag}, 8'h01);
    bwr(2'd2, 8'h04);
    chk("R9 flag cleared", {7'd0, irq_flag}, 8'h00);
    bwr(2'd2, ctl(0, 0, 1));
    chk("R9 writing one no set", {7'd0, irq_flag}, 8'h00);

    // R3 data holder retention
    read_byte(9, v);
    bwr(2'd0, 8'd5); bwr(2'd3, 8'h55); bwr(2'd2, ctl(0, 0, 1));
    peek(2'd1, v);
    chk("R3 holds after accesses", v, 8'hE1);
    bwr(2'd1, 8'h3C);
    peek(2'd1, v);
    chk("R3 software write", v, 8'h3C);

    // R8 R10 clear enable and read during busy
    bwr(2'd0, 8'd12); bwr(2'd1, 8'h96);
    key_go();
    wen_sh = 1'b0;
    bwr(2'd2, ctl(0, 0, 0));
    bwr(2'd0, 8'd9);
    bwr(2'd2, ctl(1, 0, 0));
    peek(2'd1, v);
    chk("R10 read ignored while busy", v, 8'h96);
    idle(WC);
    chk("R8 write completed", {7'd0, irq_flag}, 8'h01);
    wen_sh = 1'b1;
    bwr(2'd2, 8'h04);
    model[12] = 8'h96;
    read_byte(12, v);
    chk("R8 committed despite enable clear", v, 8'h96);

    // R2 sweep: write every address then read back
    for (int a = 0; a < N; a++) begin
      bwr(2'd0, 8'(a)); bwr(2'd1, pat(a));
      key_go();
      idle(WC);
      model[a] = pat(a);
      bwr(2'd2, 8'h04);
    end
    for (int a = N - 1; a >= 0; a--) begin
      read_byte(a, v);
      chk("R2 sweep readback", v, model[a]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule